// File: doc/BRIEF.md
# Load-Linked / Store-Conditional Reservation Table

This block keeps the load-linked reservations of a shared memory controller. Each entry holds a valid flag, a byte address and a signature key. One request per cycle arrives as an opcode, an address, a word count and a key. The result comes back combinationally in the same cycle, and any table update takes effect at the following clock edge.

A load-linked access either finds its address already reserved or claims an entry for it. If it finds the address, it reuses the stored key as long as that key is still young, and otherwise replaces it with a fresh one. A claim takes the lowest free entry. When no entry is free, a victim is picked by a masked counter. A probe operation asks whether an address/key pair is still reserved without changing anything. A store-conditional consumes the reservation. A plain store invalidates every reservation inside the byte range it writes. A clear operation empties the table. Seven event counters are exposed for statistics.

Top module: `llscTable`

## Requirements
- R1: After reset every entry is invalid, the victim counter and the next-key register are zero, and all seven event counters read zero.
- R2: Opcode encoding is LL=0, CHECK=1, SC=2, SW=3, CLEAR=4. rspValid equals reqValid in the same cycle, and rspHit/rspKey are valid in that same cycle.
- R3: An LL whose address matches a valid entry, where the absolute difference between the stored key and the next-key register is below LIFE_SPAN, returns the stored key with rspHit=1 and changes neither the table nor the next-key register.
- R4: An LL address hit whose key is not young writes the next-key value into the entry, returns that value with rspHit=1, increments the next-key register and increments the LL-update counter.
- R5: An LL that misses with a free entry available stores the address and the next-key value in the lowest-indexed free entry, returns that key with rspHit=0, increments the next-key register and does not count an eviction.
- R6: An LL that misses on a full table advances the victim counter c to ((~c & (c<<1)) & MASK) | (c+1), with MASK=0xA800 for 16 entries. It replaces the entry whose index is the highest bit set in old XOR new, and counts an eviction. Legal entry counts are 12, 16, 20, 24 and 32, and more than one processor is required.
- R7: CHECK sets rspHit only when a valid entry matches both address and key, and leaves the table unchanged.
- R8: SC on a valid entry matching address and key sets rspHit and invalidates that entry. Otherwise it sets rspHit=0 and changes nothing.
- R9: SW invalidates every valid entry whose address lies in [reqAddr, reqAddr + reqWords*BYTES_PER_WORD), and sets rspHit when at least one entry was invalidated.
- R10: CLEAR invalidates all entries and zeroes the victim counter and the next-key register. The event counters keep their values.
- R11: Separate counters advance by one for each LL, LL key update, eviction, SC, successful SC, CHECK and SW.
- R12: Opcodes 5 to 7 give rspHit=0, leave the table unchanged and advance no counter.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Request present this cycle |
| reqOp | input | 3 | Operation code |
| reqAddr | input | ADDR_W | Byte address, or range start for SW |
| reqWords | input | WORDS_W | Number of words written by SW |
| reqKey | input | KEY_W | Key for CHECK and SC |
| rspValid | output | 1 | Response strobe, same cycle as the request |
| rspHit | output | 1 | Match / success flag |
| rspKey | output | KEY_W | Key returned by LL |
| cntEvict | output | CNT_W | Evictions |
| cntLl | output | CNT_W | LL operations |
| cntLlUpd | output | CNT_W | LL key refreshes |
| cntSc | output | CNT_W | SC operations |
| cntScOk | output | CNT_W | Successful SC operations |
| cntCheck | output | CNT_W | CHECK operations |
| cntSw | output | CNT_W | SW operations |

## Verification
The bench tests the key-age boundary on both sides: a difference of seven keeps the old key and a difference of eight refreshes it. A design with an off-by-one comparison would refresh too early or too late. It also confirms that a CHECK repeated after a hit still hits, so a design that consumes reservations on a probe fails, and it places SW range edges exactly at the first and the one-past-last word to catch inclusive/exclusive mistakes. On a full table it frees one entry with SC before the next LL, then drives three evictions whose victims (entries 0, 1, then 0 again) follow the counter formula. A wrong priority or wrong victim bit would show up as a stale reservation that still hits.

// File: rtl/llscPkg.sv
package llscPkg;

  typedef enum logic [2:0] {
    OP_LL    = 3'd0,
    OP_CHECK = 3'd1,
    OP_SC    = 3'd2,
    OP_SW    = 3'd3,
    OP_CLEAR = 3'd4
  } llscOpE;

  // one-hot strobes from control to datapath
  typedef struct packed {
    logic ll;
    logic check;
    logic sc;
    logic sw;
    logic clear;
  } llscCtrlS;

  // mask that shapes the victim counter for a given entry count
  function automatic logic [63:0] victimMask(input int slots);
    case (slots)
      12:      victimMask = 64'h0;
      16:      victimMask = 64'hA800;
      20:      victimMask = 64'hD5500;
      24:      victimMask = 64'hDB5540;
      32:      victimMask = 64'hF776D550;
      default: victimMask = 64'h0;
    endcase
  endfunction

  function automatic bit slotsLegal(input int slots);
    slotsLegal = (slots == 12) || (slots == 16) || (slots == 20) ||
                 (slots == 24) || (slots == 32);
  endfunction

endpackage

// File: rtl/llscCtrl.sv
module llscCtrl
  import llscPkg::*;
(
  input  logic       reqValid,
  input  logic [2:0] reqOp,
  output llscCtrlS   ctl
);
  always_comb begin
    ctl = '0;
    if (reqValid) begin
      case (reqOp)
        OP_LL:    ctl.ll    = 1'b1;
        OP_CHECK: ctl.check = 1'b1;
        OP_SC:    ctl.sc    = 1'b1;
        OP_SW:    ctl.sw    = 1'b1;
        OP_CLEAR: ctl.clear = 1'b1;
        default:  ctl = '0;
      endcase
    end
  end
endmodule

// File: rtl/llscData.sv
module llscData
  import llscPkg::*;
#(
  parameter int SLOTS          = 16,
  parameter int ADDR_W         = 32,
  parameter int KEY_W          = 32,
  parameter int WORDS_W        = 4,
  parameter int BYTES_PER_WORD = 4,
  parameter int LIFE_SPAN      = 8,
  parameter int CNT_W          = 16
) (
  input  logic               clk,
  input  logic               rstN,
  input  llscCtrlS           ctl,
  input  logic [ADDR_W-1:0]  reqAddr,
  input  logic [WORDS_W-1:0] reqWords,
  input  logic [KEY_W-1:0]   reqKey,
  output logic               rspHit,
  output logic [KEY_W-1:0]   rspKey,
  output logic [CNT_W-1:0]   cntEvict,
  output logic [CNT_W-1:0]   cntLl,
  output logic [CNT_W-1:0]   cntLlUpd,
  output logic [CNT_W-1:0]   cntSc,
  output logic [CNT_W-1:0]   cntScOk,
  output logic [CNT_W-1:0]   cntCheck,
  output logic [CNT_W-1:0]   cntSw
);
  localparam int IDX_W  = $clog2(SLOTS);
  localparam int BPW_SH = $clog2(BYTES_PER_WORD);
  localparam logic [63:0]      MASK_ALL = victimMask(SLOTS);
  localparam logic [SLOTS-1:0] MASK     = MASK_ALL[SLOTS-1:0];
  localparam logic [KEY_W-1:0] LIFE     = KEY_W'(LIFE_SPAN);

  logic [SLOTS-1:0]  slotVld;
  logic [ADDR_W-1:0] slotAddr [SLOTS];
  logic [KEY_W-1:0]  slotKey  [SLOTS];
  logic [SLOTS-1:0]  vicCnt;
  logic [KEY_W-1:0]  nextKey;

  logic [SLOTS-1:0]  addrEq, keyEq, inRng;
  logic [ADDR_W:0]   rngLo, rngHi;

  assign rngLo = {1'b0, reqAddr};
  assign rngHi = rngLo + ({{(ADDR_W + 1 - WORDS_W){1'b0}}, reqWords} << BPW_SH);

  // parallel compare of every entry
  for (genvar i = 0; i < SLOTS; i++) begin : gCmp
    assign addrEq[i] = slotVld[i] && (slotAddr[i] == reqAddr);
    assign keyEq[i]  = addrEq[i] && (slotKey[i] == reqKey);
    assign inRng[i]  = slotVld[i] && ({1'b0, slotAddr[i]} >= rngLo) &&
                       ({1'b0, slotAddr[i]} < rngHi);
  end

  function automatic logic [IDX_W-1:0] lowestSet(input logic [SLOTS-1:0] v);
    lowestSet = '0;
    for (int i = SLOTS - 1; i >= 0; i--) if (v[i]) lowestSet = IDX_W'(i);
  endfunction

  function automatic logic [IDX_W-1:0] highestSet(input logic [SLOTS-1:0] v);
    highestSet = '0;
    for (int i = 0; i < SLOTS; i++) if (v[i]) highestSet = IDX_W'(i);
  endfunction

  logic [IDX_W-1:0] addrIdx, keyIdx, freeIdx, vicIdx, allocIdx;
  logic [SLOTS-1:0] newCnt;
  logic [KEY_W-1:0] keyAge;
  logic             anyAddr, anyKey, tableFull, keyYoung;

  always_comb begin
    addrIdx   = lowestSet(addrEq);
    keyIdx    = lowestSet(keyEq);
    freeIdx   = lowestSet(~slotVld);
    anyAddr   = |addrEq;
    anyKey    = |keyEq;
    tableFull = &slotVld;
    newCnt    = ((~vicCnt & (vicCnt << 1)) & MASK) | (vicCnt + 1'b1);
    vicIdx    = highestSet(vicCnt ^ newCnt);
    allocIdx  = tableFull ? vicIdx : freeIdx;
    keyAge    = (slotKey[addrIdx] > nextKey) ? slotKey[addrIdx] - nextKey
                                             : nextKey - slotKey[addrIdx];
    keyYoung  = keyAge < LIFE;
  end

  always_comb begin
    rspHit = 1'b0;
    rspKey = '0;
    if (ctl.ll) begin
      rspHit = anyAddr;
      rspKey = (anyAddr && keyYoung) ? slotKey[addrIdx] : nextKey;
    end else if (ctl.check || ctl.sc) begin
      rspHit = anyKey;
    end else if (ctl.sw) begin
      rspHit = |inRng;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      slotVld  <= '0;
      vicCnt   <= '0;
      nextKey  <= '0;
      cntEvict <= '0;
      cntLl    <= '0;
      cntLlUpd <= '0;
      cntSc    <= '0;
      cntScOk  <= '0;
      cntCheck <= '0;
      cntSw    <= '0;
    end else begin
      if (ctl.clear) begin
        slotVld <= '0;
        vicCnt  <= '0;
        nextKey <= '0;
      end
      if (ctl.ll) begin
        cntLl <= cntLl + 1'b1;
        if (anyAddr) begin
          if (!keyYoung) begin
            slotKey[addrIdx] <= nextKey;
            nextKey          <= nextKey + 1'b1;
            cntLlUpd         <= cntLlUpd + 1'b1;
          end
        end else begin
          slotVld[allocIdx]  <= 1'b1;
          slotAddr[allocIdx] <= reqAddr;
          slotKey[allocIdx]  <= nextKey;
          nextKey            <= nextKey + 1'b1;
          if (tableFull) begin
            vicCnt   <= newCnt;
            cntEvict <= cntEvict + 1'b1;
          end
        end
      end
      if (ctl.check) cntCheck <= cntCheck + 1'b1;
      if (ctl.sc) begin
        cntSc <= cntSc + 1'b1;
        if (anyKey) begin
          slotVld[keyIdx] <= 1'b0;
          cntScOk         <= cntScOk + 1'b1;
        end
      end
      if (ctl.sw) begin
        cntSw   <= cntSw + 1'b1;
        slotVld <= slotVld & ~inRng;
      end
    end
  end
endmodule

// File: rtl/llscTable.sv
module llscTable
  import llscPkg::*;
#(
  parameter int SLOTS          = 16,
  parameter int NUM_PROCS      = 4,
  parameter int ADDR_W         = 32,
  parameter int KEY_W          = 32,
  parameter int WORDS_W        = 4,
  parameter int BYTES_PER_WORD = 4,
  parameter int LIFE_SPAN      = 8,
  parameter int CNT_W          = 16
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               reqValid,
  input  logic [2:0]         reqOp,
  input  logic [ADDR_W-1:0]  reqAddr,
  input  logic [WORDS_W-1:0] reqWords,
  input  logic [KEY_W-1:0]   reqKey,
  output logic               rspValid,
  output logic               rspHit,
  output logic [KEY_W-1:0]   rspKey,
  output logic [CNT_W-1:0]   cntEvict,
  output logic [CNT_W-1:0]   cntLl,
  output logic [CNT_W-1:0]   cntLlUpd,
  output logic [CNT_W-1:0]   cntSc,
  output logic [CNT_W-1:0]   cntScOk,
  output logic [CNT_W-1:0]   cntCheck,
  output logic [CNT_W-1:0]   cntSw
);
  // R6: entry count and processor count are checked at elaboration
  if (!slotsLegal(SLOTS) || NUM_PROCS < 2) begin : gBadConfig
    $error("llscTable: illegal SLOTS or NUM_PROCS");
  end

  llscCtrlS ctl;

  assign rspValid = reqValid;

  llscCtrl uCtrl (
    .reqValid (reqValid),
    .reqOp    (reqOp),
    .ctl      (ctl)
  );

  llscData #(
    .SLOTS(SLOTS), .ADDR_W(ADDR_W), .KEY_W(KEY_W), .WORDS_W(WORDS_W),
    .BYTES_PER_WORD(BYTES_PER_WORD), .LIFE_SPAN(LIFE_SPAN), .CNT_W(CNT_W)
  ) uData (
    .clk(clk), .rstN(rstN), .ctl(ctl),
    .reqAddr(reqAddr), .reqWords(reqWords), .reqKey(reqKey),
    .rspHit(rspHit), .rspKey(rspKey),
    .cntEvict(cntEvict), .cntLl(cntLl), .cntLlUpd(cntLlUpd),
    .cntSc(cntSc), .cntScOk(cntScOk), .cntCheck(cntCheck), .cntSw(cntSw)
  );
endmodule

// File: rtl/llscChecker.sv
module llscChecker #(
  parameter int KEY_W = 32,
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rstN,
  input logic             reqValid,
  input logic [2:0]       reqOp,
  input logic             rspHit,
  input logic [KEY_W-1:0] rspKey,
  input logic [CNT_W-1:0] cntEvict,
  input logic [CNT_W-1:0] cntLl,
  input logic [CNT_W-1:0] cntLlUpd,
  input logic [CNT_W-1:0] cntSc,
  input logic [CNT_W-1:0] cntScOk,
  input logic [CNT_W-1:0] cntCheck,
  input logic [CNT_W-1:0] cntSw
);
  logic isLl, isCheck, isSc, isClear;
  assign isLl    = reqValid && (reqOp == 3'd0);
  assign isCheck = reqValid && (reqOp == 3'd1);
  assign isSc    = reqValid && (reqOp == 3'd2);
  assign isClear = reqValid && (reqOp == 3'd4);

  AST_SC_OK_BOUNDED: assert property (@(posedge clk) disable iff (!rstN)
    cntScOk <= cntSc); // R11

  AST_LL_SUBCOUNTS_BOUNDED: assert property (@(posedge clk) disable iff (!rstN)
    (cntLlUpd <= cntLl) && (cntEvict <= cntLl)); // R11

  AST_CHECK_KEEPS_STATE: assert property (@(posedge clk) disable iff (!rstN)
    isCheck |=> $stable(cntLl) && $stable(cntSc) && $stable(cntSw) &&
                $stable(cntEvict) && (cntCheck == $past(cntCheck) + 1'b1)); // R7

  AST_SC_HIT_COUNTED: assert property (@(posedge clk) disable iff (!rstN)
    (isSc && rspHit) |=> cntScOk == $past(cntScOk) + 1'b1); // R8

  AST_EVICT_ONLY_ON_LL: assert property (@(posedge clk) disable iff (!rstN)
    !isLl |=> $stable(cntEvict)); // R6

  AST_CLEAR_RESTARTS_KEYS: assert property (@(posedge clk) disable iff (!rstN)
    ($past(isClear) && isLl) |-> (!rspHit && rspKey == '0)); // R10
endmodule

bind llscTable llscChecker #(.KEY_W(KEY_W), .CNT_W(CNT_W)) uChk (
  .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqOp(reqOp),
  .rspHit(rspHit), .rspKey(rspKey),
  .cntEvict(cntEvict), .cntLl(cntLl), .cntLlUpd(cntLlUpd), .cntSc(cntSc),
  .cntScOk(cntScOk), .cntCheck(cntCheck), .cntSw(cntSw)
);

// File: tb/tb_llscTable.sv
module tb_llscTable;
  localparam int CNT_W = 16;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        reqValid = 1'b0;
  logic [2:0]  reqOp = 3'd0;
  logic [31:0] reqAddr = '0;
  logic [3:0]  reqWords = '0;
  logic [31:0] reqKey = '0;
  logic        rspValid, rspHit;
  logic [31:0] rspKey;
  logic [CNT_W-1:0] cntEvict, cntLl, cntLlUpd, cntSc, cntScOk, cntCheck, cntSw;

  int nChecks = 0;
  int nErrors = 0;

  always #4 clk = ~clk;  // 125 MHz

  llscTable dut (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqOp(reqOp),
    .reqAddr(reqAddr), .reqWords(reqWords), .reqKey(reqKey),
    .rspValid(rspValid), .rspHit(rspHit), .rspKey(rspKey),
    .cntEvict(cntEvict), .cntLl(cntLl), .cntLlUpd(cntLlUpd), .cntSc(cntSc),
    .cntScOk(cntScOk), .cntCheck(cntCheck), .cntSw(cntSw)
  );

  localparam logic [2:0] LL = 3'd0, CK = 3'd1, SC = 3'd2, SW = 3'd3, CL = 3'd4;

  typedef struct packed {
    logic [2:0]  op;
    logic [31:0] addr;
    logic [3:0]  words;
    logic [31:0] key;
    logic        hit;
    logic [31:0] expKey;
  } vecT;

  localparam int NV = 28;
  localparam vecT VEC [NV] = '{
    '{LL, 32'h100, 4'd0, 32'd0, 1'b0, 32'd0},  // R5 first claim
    '{LL, 32'h100, 4'd0, 32'd0, 1'b1, 32'd0},  // R3 young reuse
    '{CK, 32'h100, 4'd0, 32'd0, 1'b1, 32'd0},  // R7
    '{CK, 32'h100, 4'd0, 32'd5, 1'b0, 32'd0},  // R7 wrong key
    '{CK, 32'h100, 4'd0, 32'd0, 1'b1, 32'd0},  // R7 not consumed
    '{LL, 32'h200, 4'd0, 32'd0, 1'b0, 32'd1},  // R5
    '{LL, 32'h204, 4'd0, 32'd0, 1'b0, 32'd2},
    '{LL, 32'h208, 4'd0, 32'd0, 1'b0, 32'd3},
    '{LL, 32'h20C, 4'd0, 32'd0, 1'b0, 32'd4},
    '{LL, 32'h210, 4'd0, 32'd0, 1'b0, 32'd5},
    '{LL, 32'h214, 4'd0, 32'd0, 1'b0, 32'd6},
    '{LL, 32'h100, 4'd0, 32'd0, 1'b1, 32'd0},  // R3 age 7 still young
    '{LL, 32'h218, 4'd0, 32'd0, 1'b0, 32'd7},
    '{LL, 32'h100, 4'd0, 32'd0, 1'b1, 32'd8},  // R4 age 8 refresh
    '{CK, 32'h100, 4'd0, 32'd0, 1'b0, 32'd0},  // R4 old key gone
    '{CK, 32'h100, 4'd0, 32'd8, 1'b1, 32'd0},  // R4 new key held
    '{SC, 32'h100, 4'd0, 32'd0, 1'b0, 32'd0},  // R8 stale key
    '{SC, 32'h100, 4'd0, 32'd8, 1'b1, 32'd0},  // R8 success
    '{CK, 32'h100, 4'd0, 32'd8, 1'b0, 32'd0},  // R8 consumed
    '{SW, 32'h204, 4'd2, 32'd0, 1'b1, 32'd0},  // R9 range 0x204..0x20B
    '{CK, 32'h200, 4'd0, 32'd1, 1'b1, 32'd0},  // R9 below range
    '{CK, 32'h204, 4'd0, 32'd2, 1'b0, 32'd0},  // R9 first word
    '{CK, 32'h208, 4'd0, 32'd3, 1'b0, 32'd0},  // R9 last word
    '{CK, 32'h20C, 4'd0, 32'd4, 1'b1, 32'd0},  // R9 one past end
    '{SW, 32'h400, 4'd4, 32'd0, 1'b0, 32'd0},  // R9 empty range
    '{CL, 32'h0,   4'd0, 32'd0, 1'b0, 32'd0},  // R10
    '{CK, 32'h200, 4'd0, 32'd1, 1'b0, 32'd0},  // R10 table emptied
    '{LL, 32'h100, 4'd0, 32'd0, 1'b0, 32'd0}   // R10 key restarts
  };

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    nChecks++;
    if (act !== exp) begin
      nErrors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // drive at negedge, sample before the committing edge
  task automatic issue(input logic [2:0] op, input logic [31:0] a, input logic [3:0] w,
                       input logic [31:0] k, output logic hit, output logic [31:0] key);
    @(negedge clk);
    reqValid = 1'b1; reqOp = op; reqAddr = a; reqWords = w; reqKey = k;
    #2;
    hit = rspHit;
    key = rspKey;
    @(posedge clk);
    #1 reqValid = 1'b0;
  endtask

  initial begin
    #(8 * 100000);
    nErrors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", nChecks, nErrors);
    $finish;
  end

  initial begin
    logic h;
    logic [31:0] k;
    int nLl, nCk, nSc, nScOk, nSw;
    nLl = 0; nCk = 0; nSc = 0; nScOk = 0; nSw = 0;

    repeat (3) @(posedge clk);
    #1 rstN = 1'b1;
    @(negedge clk);
    check("R1 rspValid idle", rspValid, 0);
    check("R1 counters zero", {cntEvict, cntLl, cntLlUpd, cntSc, cntScOk, cntCheck, cntSw}, 0);

    @(negedge clk);
    reqValid = 1'b1; reqOp = CK; reqAddr = 32'h100; reqKey = 0;
    #1 check("R2 rspValid follows reqValid", rspValid, 1);
    check("R1 empty table no hit", rspHit, 0);
    reqValid = 1'b0;

    for (int i = 0; i < NV; i++) begin
      issue(VEC[i].op, VEC[i].addr, VEC[i].words, VEC[i].key, h, k);
      check($sformatf("vector %0d hit", i), h, VEC[i].hit);
      if (VEC[i].op == LL) begin
        check($sformatf("vector %0d key", i), k, VEC[i].expKey);
        nLl++;
      end
      if (VEC[i].op == CK) nCk++;
      if (VEC[i].op == SC) begin nSc++; if (VEC[i].hit) nScOk++; end
      if (VEC[i].op == SW) nSw++;
    end

    @(negedge clk);
    check("R11 LL count", cntLl, nLl);
    check("R11 CHECK count", cntCheck, nCk);
    check("R11 SC count", cntSc, nSc);
    check("R11 SC ok count", cntScOk, nScOk);
    check("R11 SW count", cntSw, nSw);
    check("R4 LL update count", cntLlUpd, 1);
    check("R5 no eviction with free slots", cntEvict, 0);

    // R12: unused opcode has no effect
    issue(3'd5, 32'h100, 4'd0, 32'd0, h, k);
    check("R12 unused op no hit", h, 0);
    @(negedge clk);
    check("R12 counters unchanged",
          {cntEvict, cntLl, cntLlUpd, cntSc, cntScOk, cntCheck, cntSw},
          {16'd0, 16'(nLl), 16'd1, 16'(nSc), 16'(nScOk), 16'(nCk), 16'(nSw)});
    issue(CK, 32'h100, 4'd0, 32'd0, h, k);
    check("R12 reservation intact", h, 1);

    // Eviction scenario after a fresh reset
    @(negedge clk); rstN = 1'b0;
    @(posedge clk); #1 rstN = 1'b1;
    @(negedge clk);
    check("R1 counters cleared by reset", {cntLl, cntCheck, cntSc}, 0);
    for (int i = 0; i < 16; i++) begin
      issue(LL, 32'h1000 + 32'(i * 4), 4'd0, 32'd0, h, k);
      if (i == 15) check("R5 fill last key", k, 15);
    end
    issue(SC, 32'h1014, 4'd0, 32'd5, h, k);
    check("R8 free entry 5", h, 1);
    issue(LL, 32'h2000, 4'd0, 32'd0, h, k);
    check("R5 refill freed entry key", k, 16);
    @(negedge clk);
    check("R5 refill no eviction", cntEvict, 0);
    // victims by formula: c 0->1 (entry 0), 1->2 (entry 1), 2->3 (entry 0)
    issue(LL, 32'h2004, 4'd0, 32'd0, h, k);
    check("R6 evict key", k, 17);
    issue(LL, 32'h2008, 4'd0, 32'd0, h, k);
    issue(LL, 32'h200C, 4'd0, 32'd0, h, k);
    check("R6 third evict key", k, 19);
    @(negedge clk);
    check("R6 eviction count", cntEvict, 3);
    issue(CK, 32'h1000, 4'd0, 32'd0, h, k);
    check("R6 entry 0 evicted", h, 0);
    issue(CK, 32'h1004, 4'd0, 32'd1, h, k);
    check("R6 entry 1 evicted", h, 0);
    issue(CK, 32'h2004, 4'd0, 32'd17, h, k);
    check("R6 entry 0 re-evicted", h, 0);
    issue(CK, 32'h200C, 4'd0, 32'd19, h, k);
    check("R6 newest held", h, 1);
    issue(CK, 32'h1008, 4'd0, 32'd2, h, k);
    check("R6 entry 2 untouched", h, 1);
    issue(CK, 32'h2000, 4'd0, 32'd16, h, k);
    check("R5 refilled entry held", h, 1);

    $display("Simulation finished: %0d checks, %0d errors", nChecks, nErrors);
    $finish;
  end
endmodule